// File: doc/BRIEF.md
# Shared-Bus SPI Slave Selector

This block lives on every slave board of a shared SPI bus. The bus carries the serial clock, the outgoing data line and the return data line. It also carries two active-low strobes that are shared by every board. The block turns those two strobes into a private active-low select for the local SPI device.

A transaction has two phases. In the addressing phase, the master holds the addressing strobe low and clocks one byte over MOSI. Every board shifts that byte in, most significant bit first. When the addressing strobe returns high, each board copies the byte into a holding register. In the data phase, the master holds the data strobe low. Each board then drives one bit of its holding register onto its local select, and a zero in that bit selects the board. Which bit a board watches is fixed at build time by the `SEL_BIT` parameter. As a result, one select wire per slave becomes two shared wires plus one in-band byte.

The serial inputs are sampled by a faster local clock through a synchronizer, and the addressing sequence is run by a small state machine with three states:
- `ST_IDLE` waits while the addressing strobe is high.
- `ST_SHIFT` is entered when the strobe goes low. It shifts on each rising SCLK edge.
- `ST_LOAD` is entered from `ST_SHIFT` on the rising edge of the strobe. It copies the shift register into the holding register for one cycle. It then returns to `ST_IDLE`, or to `ST_SHIFT` if the strobe is already low again.

The output gate is purely combinational from the data strobe. It also produces an enable for the local MISO driver, so that a board that is not selected never drives the shared return line.

Top module: `spi_addr_select`

## Requirements
- R1: While the synchronized addressing strobe is low, every rising SCLK edge shifts MOSI into the shift register, most significant bit first. After 8 bits, byte bit 7 sits in register bit 7.
- R2: SCLK edges that occur while the addressing strobe is high leave the shift register unchanged.
- R3: The holding register loads the shift register only on a rising edge of the addressing strobe. Throughout an addressing phase it keeps its previous value.
- R4: While the data strobe is low, `ss_n` equals holding-register bit `SEL_BIT`. A 0 selects the board.
- R5: While the data strobe is high, `ss_n` is 1 at once. The path from the strobe is combinational, so `ss_n` never goes low while the strobe is high.
- R6: `miso_oe` is 1 exactly when `ss_n` is 0.
- R7: Reset sets both the shift register and the holding register to all ones, so no board is selected until a byte has been latched.
- R8: A latched byte with several zero bits selects every board whose `SEL_BIT` lands on a zero (broadcast).
- R9: If the addressing strobe rises after fewer than 8 SCLK edges, the partially shifted contents are latched as they are, with no count check.
- R10: The parameter `SEL_BIT` alone decides which latched bit drives `ss_n`. Two boards with `SEL_BIT` 3 and 0 respond to bits 3 and 0 of the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shared SPI serial clock (mode 0) |
| mosi | input | 1 | Shared master-to-slave data |
| asel_n | input | 1 | Shared active-low addressing strobe |
| dsel_n | input | 1 | Shared active-low data strobe |
| ss_n | output | 1 | Local active-low select for the attached device |
| miso_oe | output | 1 | Enable for the local MISO driver |

## Verification
The bench sends addressing bytes whose bit 3 differs from the bit 3 of their bit-reversed form. A design that shifts least significant bit first would therefore select the wrong boards. It toggles SCLK while the addressing strobe is high and then latches a zero-length byte. A design that shifts without regard to the strobe would lose its selection. It latches partial bytes of 1 and 4 bits and checks the select during an addressing phase. A design that clears the register on entry, or loads it early, would show a wrong select level. It also compares two instances with different `SEL_BIT` values on broadcast bytes, and checks that a reset in mid-operation drops the selection.

// File: rtl/spi_addr_select_pkg.sv
package spi_addr_select_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2
    } ssel_state_e;

endpackage

// File: rtl/spi_addr_sync.sv
module spi_addr_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_addr_shifter.sv
module spi_addr_shifter
    import spi_addr_select_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_sclk,
    input  logic             s_mosi,
    input  logic             s_asel,
    output ssel_state_e      state_o,
    output logic [WIDTH-1:0] shreg_o,
    output logic [WIDTH-1:0] latch_o
);

    ssel_state_e      state, state_nx;
    logic             sclk_q, asel_q;
    logic             sclk_rise, asel_rise, shift_en;
    logic [WIDTH-1:0] shreg, latch;

    assign sclk_rise = s_sclk & ~sclk_q;
    assign asel_rise = s_asel & ~asel_q;
    assign shift_en  = sclk_rise & ~s_asel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!s_asel)   state_nx = ST_SHIFT;
            ST_SHIFT: if (asel_rise) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = s_asel ? ST_IDLE : ST_SHIFT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            asel_q <= 1'b1;
            shreg  <= '1;
            latch  <= '1;
        end else begin
            sclk_q <= s_sclk;
            asel_q <= s_asel;
            if (shift_en)
                shreg <= {shreg[WIDTH-2:0], s_mosi};
            if (state == ST_LOAD)
                latch <= shreg;
        end
    end

    assign state_o = state;
    assign shreg_o = shreg;
    assign latch_o = latch;

endmodule

// File: rtl/spi_addr_gate.sv
module spi_addr_gate #(
    parameter int WIDTH   = 8,
    parameter int SEL_BIT = 3
) (
    input  logic [WIDTH-1:0] latch,
    input  logic             dsel_n,
    output logic             ss_n,
    output logic             miso_oe
);

    logic pick;

    if (SEL_BIT < WIDTH) begin : g_valid
        assign pick = latch[SEL_BIT];
    end else begin : g_none
        assign pick = 1'b1;
    end

    // OR gate: a high strobe forces the select inactive with no clocked path
    assign ss_n    = dsel_n | pick;
    assign miso_oe = ~ss_n;

endmodule

// File: rtl/spi_addr_select.sv
module spi_addr_select
    import spi_addr_select_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SEL_BIT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic mosi,
    input  logic asel_n,
    input  logic dsel_n,
    output logic ss_n,
    output logic miso_oe
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, synced;
    logic              s_sclk, s_mosi, s_asel;
    ssel_state_e       state;
    logic [WIDTH-1:0]  shreg, latch_q;

    assign raw_in = {sclk, mosi, asel_n};

    spi_addr_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    assign s_sclk = synced[2];
    assign s_mosi = synced[1];
    assign s_asel = synced[0];

    spi_addr_shifter #(
        .WIDTH (WIDTH)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_sclk  (s_sclk),
        .s_mosi  (s_mosi),
        .s_asel  (s_asel),
        .state_o (state),
        .shreg_o (shreg),
        .latch_o (latch_q)
    );

    spi_addr_gate #(
        .WIDTH   (WIDTH),
        .SEL_BIT (SEL_BIT)
    ) u_gate (
        .latch   (latch_q),
        .dsel_n  (dsel_n),
        .ss_n    (ss_n),
        .miso_oe (miso_oe)
    );

endmodule

// File: rtl/spi_addr_select_chk.sv
module spi_addr_select_chk
    import spi_addr_select_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dsel_n,
    input logic             ss_n,
    input logic             miso_oe,
    input logic             s_asel,
    input ssel_state_e      state,
    input logic [WIDTH-1:0] shreg,
    input logic [WIDTH-1:0] latch_q
);

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_asel |=> $stable(shreg)); // R2

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD) |=> $stable(latch_q)); // R3

    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (latch_q == $past(shreg))); // R3

    AST_DSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        dsel_n |-> ss_n); // R5

    AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe == !ss_n); // R6

    AST_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state != ST_LOAD)); // R3

endmodule

bind spi_addr_select spi_addr_select_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dsel_n  (dsel_n),
    .ss_n    (ss_n),
    .miso_oe (miso_oe),
    .s_asel  (s_asel),
    .state   (state),
    .shreg   (shreg),
    .latch_q (latch_q)
);

// File: tb/test_spi_addr_select.sv
`timescale 1ns/1ps
module test_spi_addr_select;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, asel_n = 1'b1, dsel_n = 1'b1;
    logic ss_n, miso_oe, ss_b0, oe_b0;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    spi_addr_select #(.SEL_BIT(3)) i_spi_addr_select (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
        .asel_n(asel_n), .dsel_n(dsel_n), .ss_n(ss_n), .miso_oe(miso_oe)
    );

    spi_addr_select #(.SEL_BIT(0)) i_spi_addr_select_b0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi),
        .asel_n(asel_n), .dsel_n(dsel_n), .ss_n(ss_b0), .miso_oe(oe_b0)
    );

    // {address byte, expected ss_n of the SEL_BIT=3 board}
    localparam logic [8:0] VEC [10] = '{
        {8'hF7, 1'b0}, {8'hFE, 1'b1}, {8'h00, 1'b0}, {8'hFF, 1'b1},
        {8'hEF, 1'b1}, {8'h77, 1'b0}, {8'h08, 1'b1}, {8'h5A, 1'b1},
        {8'hA5, 1'b0}, {8'hF7, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic addr_begin();
        asel_n = 1'b0;
        clks(4);
    endtask

    task automatic shift_bit(input logic b);
        mosi = b;
        clks(3);
        sclk = 1'b1;
        clks(4);
        sclk = 1'b0;
        clks(4);
    endtask

    task automatic addr_end();
        asel_n = 1'b1;
        clks(8);
    endtask

    task automatic send_byte(input logic [7:0] b);
        addr_begin();
        for (int i = 7; i >= 0; i--) shift_bit(b[i]);
        addr_end();
    endtask

    // data phase: select level with strobe low, forced high with strobe high
    task automatic check_sel(input string req, input logic e3, input logic e0);
        dsel_n = 1'b0;
        #1;
        chk(req, ss_n, e3);
        chk({req, "/R6"}, miso_oe, ~e3);
        chk({req, "/R10"}, ss_b0, e0);
        dsel_n = 1'b1;
        #1;
        chk("R5", ss_n, 1'b1);
        chk("R5", ss_b0, 1'b1);
        clks(1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        clks(3);
        // R7: reset state, nothing selected
        dsel_n = 1'b0;
        #1;
        chk("R7", ss_n, 1'b1);
        chk("R7/R6", miso_oe, 1'b0);
        dsel_n = 1'b1;
        rst_n = 1'b1;
        clks(2);
        check_sel("R7", 1'b1, 1'b1);

        // R1, R4, R8: vector table
        foreach (VEC[k]) begin
            send_byte(VEC[k][8:1]);
            check_sel((VEC[k][8:1] == 8'h00 || VEC[k][8:1] == 8'h77) ? "R8" : "R1/R4",
                      VEC[k][0], VEC[k][4 - 3]);
        end

        // R2: SCLK activity with addressing strobe high; shift reg still F7
        mosi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b1; clks(4);
            sclk = 1'b0; clks(4);
        end
        addr_begin();
        addr_end();
        check_sel("R2", 1'b0, 1'b1);

        // R9: partial byte of one bit: F7 -> EF
        addr_begin();
        shift_bit(1'b1);
        addr_end();
        check_sel("R9", 1'b1, 1'b1);
        // R9: four bits 0111: EF -> F7
        addr_begin();
        shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
        addr_end();
        check_sel("R9", 1'b0, 1'b1);

        // R3: holding register kept through an addressing phase
        addr_begin();
        for (int i = 0; i < 4; i++) shift_bit(1'b1);
        check_sel("R3", 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) shift_bit(1'b1);
        check_sel("R3", 1'b0, 1'b1);
        addr_end();
        check_sel("R3", 1'b1, 1'b1);

        // R10: bit 0 board selected, bit 3 board not
        send_byte(8'hFE);
        check_sel("R10", 1'b1, 1'b0);

        // R5: strobe high with a selecting latch
        send_byte(8'hF6);
        dsel_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #3;
            chk("R5", ss_n, 1'b1);
            chk("R5", ss_b0, 1'b1);
        end
        check_sel("R8", 1'b0, 1'b0);

        // R7: reset in mid-operation drops the selection
        rst_n = 1'b0;
        clks(2);
        rst_n = 1'b1;
        clks(2);
        check_sel("R7", 1'b1, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule